// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial command decoder of a byte-wide nonvolatile memory. It gathers the data bytes of one write transaction into a small page buffer, then programs them into the storage array with a self-timed cycle. The decoder announces a transaction with a start strobe and the target address, then delivers each received data byte with a one-cycle valid strobe. When chip select rises, the decoder pulses a rise event and a flag. The flag is high when the rise came directly after the last bit of a whole byte. The decoder also passes the current state of the write-enable latch.

The address is split into a fixed page number and an offset within the page. Each stored byte moves only the offset, so a long burst wraps and later bytes replace earlier ones in the same slot. A commit starts only when chip select rises on a byte boundary with the write-enable latch set and at least one byte buffered. It then walks the page slots in order and presents every buffered byte on the array port. The neighbouring protection block answers each presented address with a grant, and only granted bytes are written. Busy stays high for a parameterised number of clocks. A one-cycle done pulse in the final busy cycle tells the protection block to clear the write-enable latch.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy`, `arrWe` and `cycleDone` are low.
- R2: The k-th data byte (k from 0) is stored at page offset (start offset + k) mod PAGE_BYTES. The page number, which is the address bits above the offset, is taken from `startAddr` and stays fixed for the whole commit.
- R3: When more than PAGE_BYTES bytes arrive, a later byte replaces the earlier one in the same slot, and only the latest value is written.
- R4: Only slots that received a byte are written, and each is written once per commit. Every other array location keeps its contents.
- R5: A commit starts only if `csRise` comes while collecting, with `csAligned` high, `wenLatch` high and at least one byte buffered. Otherwise the whole buffer is discarded and no write, busy or done follows.
- R6: A buffered byte is written only if `wrGrant` is high for its own address while it is presented. A denied byte is skipped, and the other bytes of the page are still written.
- R7: `busy` rises in the cycle after the accepted `csRise`. It stays high for exactly CYCLE_CLKS consecutive cycles.
- R8: `cycleDone` is high for exactly one cycle per commit, in the last busy cycle.
- R9: While busy, `startValid`, `byteValid` and `csRise` have no effect on the data written, the busy length or the number of done pulses.
- R10: `arrWe` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Opens a write transaction and loads the start address |
| startAddr | input | ADDR_W | First byte address of the transaction |
| byteValid | input | 1 | One data byte is present on byteData |
| byteData | input | 8 | Received data byte |
| csRise | input | 1 | One-cycle event: chip select went inactive |
| csAligned | input | 1 | Qualifies csRise: the rise followed a complete byte |
| wenLatch | input | 1 | State of the write-enable latch |
| wrGrant | input | 1 | Protection answer for the address on arrAddr |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array address being presented |
| arrData | output | 8 | Array write data |
| busy | output | 1 | Self-timed cycle in progress |
| cycleDone | output | 1 | One-cycle pulse at the end of the cycle |

## Verification
The assertions check on every cycle that the busy window is unbroken and ends on the done pulse, and that the done pulse lasts one cycle. They also check that a busy window opens only after a qualified chip-select rise, that the page number does not move during the walk, and that array strobes appear only while busy. The data-level behaviours can only be shown by the bench's scenarios, which compare the whole array image against an arithmetic model after each transaction. These are slot wrap and overwrite, partial-page writes, per-byte protection denial, discard on a misaligned rise or a cleared latch, and immunity to traffic while busy. The sweep covers start offsets, burst lengths beyond one page, and several pages.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PROGRAM = 2'd2
  } pwbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // latch page number and offset, clear slot flags
    logic storeByte;  // store byteData at the write pointer, advance it
    logic walkEn;     // present one page slot to the array this cycle
  } pwbCtl_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 500000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startValid,
  input  logic    byteValid,
  input  logic    csRise,
  input  logic    csAligned,
  input  logic    wenLatch,
  input  logic    anyValid,
  output pwbCtl_t ctl,
  output logic    busy,
  output logic    cycleDone
);

  localparam int TMR_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [TMR_W-1:0] LAST_T = TMR_W'(CYCLE_CLKS - 1);
  localparam logic [TMR_W-1:0] WALK_T = TMR_W'(PAGE_BYTES);

  pwbState_t        state;
  logic [TMR_W-1:0] timer;
  logic             acceptCommit;

  always_comb begin
    acceptCommit  = (state == ST_COLLECT) && csRise && csAligned && wenLatch && anyValid;
    ctl.loadStart = startValid && (state != ST_PROGRAM);
    ctl.storeByte = byteValid && (state == ST_COLLECT);
    ctl.walkEn    = (state == ST_PROGRAM) && (timer < WALK_T);
    busy          = (state == ST_PROGRAM);
    cycleDone     = (state == ST_PROGRAM) && (timer == LAST_T);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startValid) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (csRise) begin
            state <= acceptCommit ? ST_PROGRAM : ST_IDLE;
            timer <= '0;
          end
        end
        ST_PROGRAM: begin
          if (cycleDone) begin
            state <= ST_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |=> !cycleDone); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cycleDone |=> !busy); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycleDone) |=> busy); // R7
  AST_COMMIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(csRise && csAligned && wenLatch && anyValid)); // R5

endmodule

// File: rtl/pwb_data.sv
module pwb_data
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwbCtl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  input  logic              wrGrant,
  output logic              anyValid,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [PG_W-1:0]       pageBase;
  logic [OFF_W-1:0]      wrPtr;
  logic [OFF_W-1:0]      walkIdx;
  logic [7:0]            slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;
  logic [PAGE_BYTES-1:0] slotHit;

  // one decode per slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
    assign slotHit[g] = ctl.storeByte && (wrPtr == OFF_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageBase  <= '0;
      wrPtr     <= '0;
      slotValid <= '0;
    end else if (ctl.loadStart) begin
      pageBase  <= startAddr[ADDR_W-1:OFF_W];
      wrPtr     <= startAddr[OFF_W-1:0];
      slotValid <= '0;
    end else if (ctl.storeByte) begin
      wrPtr     <= wrPtr + 1'b1;  // offset wraps inside the page
      slotValid <= slotValid | slotHit;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (slotHit[i] && !ctl.loadStart) slotData[i] <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          walkIdx <= '0;
    else if (ctl.walkEn) walkIdx <= walkIdx + 1'b1;
    else                 walkIdx <= '0;
  end

  always_comb begin
    anyValid = |slotValid;
    arrAddr  = {pageBase, walkIdx};
    arrData  = slotData[walkIdx];
    arrWe    = ctl.walkEn && slotValid[walkIdx] && wrGrant;
  end

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.walkEn && $past(ctl.walkEn)) |-> $stable(pageBase)); // R2

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              csRise,
  input  logic              csAligned,
  input  logic              wenLatch,
  input  logic              wrGrant,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        arrData,
  output logic              busy,
  output logic              cycleDone
);

  pwbCtl_t ctl;
  logic    anyValid;

  pwb_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .byteValid  (byteValid),
    .csRise     (csRise),
    .csAligned  (csAligned),
    .wenLatch   (wenLatch),
    .anyValid   (anyValid),
    .ctl        (ctl),
    .busy       (busy),
    .cycleDone  (cycleDone)
  );

  pwb_data #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .startAddr (startAddr),
    .byteData  (byteData),
    .wrGrant   (wrGrant),
    .anyValid  (anyValid),
    .arrWe     (arrWe),
    .arrAddr   (arrAddr),
    .arrData   (arrData)
  );

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arrWe |-> busy); // R10

endmodule

// File: tb/test_page_write_seq.sv
module test_page_write_seq;

  localparam int ADDR_W = 10;
  localparam int PAGE   = 32;
  localparam int CYCLE  = 48;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              byteValid = 1'b0;
  logic [7:0]        byteData = '0;
  logic              csRise = 1'b0;
  logic              csAligned = 1'b0;
  logic              wenLatch = 1'b0;
  logic              wrGrant;
  logic              arrWe;
  logic [ADDR_W-1:0] arrAddr;
  logic [7:0]        arrData;
  logic              busy;
  logic              cycleDone;

  logic [ADDR_W:0]   protLimit = DEPTH[ADDR_W:0];

  always #5 clk = ~clk;

  // protection model: addresses at or above protLimit are denied
  assign wrGrant = ({1'b0, arrAddr} < protLimit);

  page_write_seq #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE),
    .CYCLE_CLKS (CYCLE)
  ) i_page_write_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .startAddr  (startAddr),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .csRise     (csRise),
    .csAligned  (csAligned),
    .wenLatch   (wenLatch),
    .wrGrant    (wrGrant),
    .arrWe      (arrWe),
    .arrAddr    (arrAddr),
    .arrData    (arrData),
    .busy       (busy),
    .cycleDone  (cycleDone)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  int busyCnt  = 0;
  int doneCnt  = 0;
  int weCnt    = 0;
  int dupCnt   = 0;
  logic [7:0] obsMem [DEPTH];
  logic [7:0] expMem [DEPTH];
  logic       wrFlag [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      obsMem[i] = 8'h00;
      expMem[i] = 8'h00;
      wrFlag[i] = 1'b0;
    end
  end

  // array model and event counters, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy)      busyCnt++;
      if (cycleDone) doneCnt++;
      if (arrWe) begin
        weCnt++;
        if (wrFlag[arrAddr]) dupCnt++;
        wrFlag[arrAddr] = 1'b1;
        obsMem[arrAddr] = arrData;
      end
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runTx(input int startA, input int nBytes, input int seed,
                       input bit aligned, input bit wen, input bit noise,
                       input string tag);
    int b0, d0, w0, u0, expW, mism;
    bit commit;
    bit       pendV [PAGE];
    int       pendD [PAGE];
    int       page, off;
    b0 = busyCnt; d0 = doneCnt; w0 = weCnt; u0 = dupCnt;
    for (int i = 0; i < DEPTH; i++) wrFlag[i] = 1'b0;
    startValid = 1'b1; startAddr = ADDR_W'(startA);
    tick;
    startValid = 1'b0;
    for (int k = 0; k < nBytes; k++) begin
      byteValid = 1'b1;
      byteData  = 8'((seed + k * 7) & 255);
      tick;
    end
    byteValid = 1'b0;
    csRise = 1'b1; csAligned = aligned; wenLatch = wen;
    tick;
    csRise = 1'b0; csAligned = 1'b0; wenLatch = 1'b0;
    if (noise) begin
      // R9: traffic while busy must not alter the commit
      for (int j = 0; j < 6; j++) begin
        byteValid = 1'b1; byteData = 8'hEE;
        startValid = 1'b1; startAddr = '0;
        csRise = 1'b1; csAligned = 1'b1; wenLatch = 1'b1;
        tick;
      end
      byteValid = 1'b0; startValid = 1'b0;
      csRise = 1'b0; csAligned = 1'b0; wenLatch = 1'b0;
    end
    repeat (CYCLE + 4) tick;

    commit = aligned && wen && (nBytes > 0);
    expW = 0;
    page = startA / PAGE;
    off  = startA % PAGE;
    for (int s = 0; s < PAGE; s++) begin
      pendV[s] = 1'b0;
      pendD[s] = 0;
    end
    if (commit) begin
      for (int k = 0; k < nBytes; k++) begin
        pendV[(off + k) % PAGE] = 1'b1;
        pendD[(off + k) % PAGE] = (seed + k * 7) & 255;
      end
      for (int s = 0; s < PAGE; s++) begin
        if (pendV[s] && ((page * PAGE + s) < int'(protLimit))) begin
          expMem[page * PAGE + s] = 8'(pendD[s]);
          expW++;
        end
      end
    end
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (obsMem[i] !== expMem[i]) mism++;

    chk(busyCnt - b0 == (commit ? CYCLE : 0), commit ? "R7" : "R5",
        {tag, " busy cycles"}, busyCnt - b0, commit ? CYCLE : 0);
    chk(doneCnt - d0 == (commit ? 1 : 0), "R8", {tag, " done pulses"},
        doneCnt - d0, commit ? 1 : 0);
    chk(weCnt - w0 == expW, "R4", {tag, " write strobes"}, weCnt - w0, expW);
    chk(dupCnt == u0, "R4", {tag, " repeated address"}, dupCnt - u0, 0);
    chk(mism == 0, "R2/R3/R6", {tag, " array image mismatches"}, mism, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin : main
    int offs [4];
    int lens [6];
    int n;
    offs = '{0, 1, 17, 31};
    lens = '{1, 2, 31, 32, 33, 70};

    repeat (3) tick;
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0,      "R1", "busy after reset",      int'(busy), 0);
    chk(arrWe == 1'b0,     "R1", "arrWe after reset",     int'(arrWe), 0);
    chk(cycleDone == 1'b0, "R1", "cycleDone after reset", int'(cycleDone), 0);
    tick;

    // R2 R3 R4 R7 R8: sweep of start offsets and burst lengths over pages
    n = 0;
    foreach (offs[i]) begin
      foreach (lens[j]) begin
        runTx(((n * 5 + 3) % (DEPTH / PAGE)) * PAGE + offs[i], lens[j],
              n * 13 + 1, 1'b1, 1'b1, 1'b0, "sweep");
        n++;
      end
    end

    // R5: misaligned rise, cleared latch, empty buffer
    runTx(4 * PAGE + 5, 10, 77, 1'b0, 1'b1, 1'b0, "misaligned");
    runTx(4 * PAGE + 5, 10, 91, 1'b1, 1'b0, 1'b0, "latch clear");
    runTx(4 * PAGE + 5, 0,  33, 1'b1, 1'b1, 1'b0, "empty");
    runTx(9 * PAGE + 30, 40, 55, 1'b0, 1'b0, 1'b0, "both off");

    // R6: per-byte protection splits a page
    protLimit = (ADDR_W + 1)'(20 * PAGE + 12);
    runTx(20 * PAGE + 8, 10, 140, 1'b1, 1'b1, 1'b0, "partial protect");
    runTx(20 * PAGE + 28, 36, 200, 1'b1, 1'b1, 1'b0, "protect wrap");
    protLimit = (ADDR_W + 1)'(0);
    runTx(2 * PAGE, 32, 9, 1'b1, 1'b1, 1'b0, "all denied");
    protLimit = DEPTH[ADDR_W:0];

    // R9 R10: traffic during busy is ignored
    runTx(11 * PAGE + 2, 32, 60, 1'b1, 1'b1, 1'b1, "busy noise");
    runTx(12 * PAGE + 31, 3, 61, 1'b1, 1'b1, 1'b1, "busy noise short");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule